// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital core of a power supervisor. It turns three reset causes into one reset pulse of fixed length: a supply-low flag from an analog comparator (already synchronised to the fast clock), an external reset request read back from the reset pins, and a watchdog. The watchdog fires when a memory chip-select line shows no transitions for too long. All pulse and watchdog timing is counted in ticks of a slow oscillator. The tick arrives as a one-cycle strobe on the fast clock, and its nominal rate is 5 kHz.

The two reset outputs are complementary, one active high and one active low. Pad drivers use them as open-drain enables. The supply flag and the external request each pass through a minimum-width filter before they can start a reset, so short spikes have no effect. One shared counter times the pulse. It restarts from zero whenever any cause is present, and it releases reset only after the full tick count has passed since the last cause went away. The watchdog counter is held at zero while reset is active. After reset releases, it counts ticks, and any rising or falling edge of chip select clears it. Chip select is synchronised through two flops before its edges are detected.

Top module: `sup_rst_seq`

## Requirements
- R1: `rst_o` and `rst_n_o` are always complementary. `rst_o`=1 means reset is active.
- R2: While `rst_n` is low, and right after it goes high, reset is active.
- R3: Reset stays active for as long as the filtered supply-low flag is high, no matter how many ticks arrive.
- R4: Once no cause is present, reset releases on the PULSE_TICKS-th tick strobe counted from that point, and never on a cycle without a tick.
- R5: A high level on `vlow_i` lasting fewer than GLITCH_CYC consecutive clock cycles has no effect. A level lasting GLITCH_CYC cycles asserts reset within two cycles after its last required sample.
- R6: An external request of only GLITCH_CYC cycles still produces a full PULSE_TICKS pulse. A request of GLITCH_CYC-1 cycles has no effect.
- R7: When reset is inactive and WDOG_TICKS tick strobes pass with no chip-select edge, reset asserts within two cycles of the last of those ticks and then runs a full pulse.
- R8: A rising edge and a falling edge of `cs_i` each restart the watchdog count from zero.
- R9: Ticks that arrive while reset is active do not advance the watchdog. After release, the full WDOG_TICKS are needed again.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| tick_i | input | 1 | One-cycle strobe from the slow oscillator |
| vlow_i | input | 1 | Synchronised supply-below-trip flag |
| cs_i | input | 1 | Chip-select line, asynchronous, watched for edges |
| ext_req_i | input | 1 | Synchronised external reset request from the pins |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
The output register follows a filtered flag, a watchdog expiry or a releasing tick by exactly one edge. The filter itself asserts on the GLITCH_CYC-th high sample, and a chip-select edge reaches the watchdog counter on the third edge after the pin changes. The bench applies every input at a falling edge and samples at falling edges. It waits two cycles after a filtered cause and four cycles after a chip-select toggle before it relies on the result. Ticks are issued one at a time, so each check falls exactly one tick short of, or exactly on, the count that should change the output.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
   localparam int unsigned DEF_GLITCH_CYC  = 8;
   localparam int unsigned DEF_PULSE_TICKS = 750;
   localparam int unsigned DEF_WDOG_TICKS  = 8000;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction
endpackage

// File: rtl/sup_glitch_flt.sv
module sup_glitch_flt #(
   parameter int unsigned MIN_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic flt_o
);
   logic flt_q;

   generate
      if (MIN_CYC <= 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flt_q <= 1'b0;
            else        flt_q <= in_i;
         end
      end else begin : g_count
         localparam int unsigned CW = sup_rst_pkg::cnt_width(MIN_CYC);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (!in_i) begin
               run_q <= '0;
               flt_q <= 1'b0;
            end else if (run_q == CW'(MIN_CYC - 1)) begin
               flt_q <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign flt_o = flt_q;

   // R5: filter output only rises after a high sample, and drops once input is low
   a_r5_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_q) |-> $past(in_i));
   a_r5_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !in_i |=> !flt_q);
endmodule

// File: rtl/sup_pulse_tmr.sv
module sup_pulse_tmr #(
   parameter int unsigned PULSE_TICKS = 750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic hold_i,
   input  logic trig_i,
   output logic rst_act_o
);
   localparam int unsigned PW = sup_rst_pkg::cnt_width(PULSE_TICKS);

   generate
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("PULSE_TICKS must be at least 1");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic          rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (hold_i || trig_i) begin
         rst_q <= 1'b1;
         cnt_q <= '0;
      end else if (rst_q && tick_i) begin
         if (cnt_q == PW'(PULSE_TICKS - 1)) begin
            rst_q <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign rst_act_o = rst_q;

   // R3: a present cause keeps reset active on the next edge
   a_r3_hold_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i || trig_i) |=> rst_q);
   // R4: release only on a tick, after the full count
   a_r4_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_q) |-> ($past(tick_i) && $past(cnt_q) == PW'(PULSE_TICKS - 1)));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int unsigned WDOG_TICKS = 8000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic cs_i,
   input  logic rst_act_i,
   output logic expire_o
);
   localparam int unsigned WW = sup_rst_pkg::cnt_width(WDOG_TICKS);

   generate
      if (WDOG_TICKS < 2) begin : g_bad_wdog
         $error("WDOG_TICKS must be at least 2");
      end
   endgenerate

   logic [2:0]    cs_sync_q;
   logic          cs_edge;
   logic [WW-1:0] wcnt_q;
   logic          exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_sync_q <= '0;
      else        cs_sync_q <= {cs_sync_q[1:0], cs_i};
   end

   assign cs_edge = cs_sync_q[2] ^ cs_sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         exp_q  <= 1'b0;
      end else if (rst_act_i || cs_edge) begin
         wcnt_q <= '0;
         exp_q  <= 1'b0;
      end else if (tick_i) begin
         if (wcnt_q == WW'(WDOG_TICKS - 1)) begin
            wcnt_q <= '0;
            exp_q  <= 1'b1;
         end else begin
            wcnt_q <= wcnt_q + 1'b1;
            exp_q  <= 1'b0;
         end
      end else begin
         exp_q <= 1'b0;
      end
   end

   assign expire_o = exp_q;

   // R9: reset holds the watchdog at zero
   a_r9_idle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      rst_act_i |=> (wcnt_q == '0 && !exp_q));
   // R8: a chip-select edge restarts the count
   a_r8_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      cs_edge |=> (wcnt_q == '0));
   // R7: expiry is a single-cycle strobe
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |=> !exp_q);
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq #(
   parameter int unsigned GLITCH_CYC  = sup_rst_pkg::DEF_GLITCH_CYC,
   parameter int unsigned PULSE_TICKS = sup_rst_pkg::DEF_PULSE_TICKS,
   parameter int unsigned WDOG_TICKS  = sup_rst_pkg::DEF_WDOG_TICKS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic vlow_i,
   input  logic cs_i,
   input  logic ext_req_i,
   output logic rst_o,
   output logic rst_n_o
);
   logic vlow_f, ext_f, wd_exp, rst_act;

   sup_glitch_flt #(.MIN_CYC(GLITCH_CYC)) u_vlow_flt (
      .clk(clk), .rst_n(rst_n), .in_i(vlow_i), .flt_o(vlow_f));

   sup_glitch_flt #(.MIN_CYC(GLITCH_CYC)) u_ext_flt (
      .clk(clk), .rst_n(rst_n), .in_i(ext_req_i), .flt_o(ext_f));

   sup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cs_i(cs_i),
      .rst_act_i(rst_act), .expire_o(wd_exp));

   sup_pulse_tmr #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(vlow_f),
      .trig_i(ext_f || wd_exp), .rst_act_o(rst_act));

   assign rst_o   = rst_act;
   assign rst_n_o = ~rst_act;

   // R7: a watchdog expiry starts a reset pulse
   a_r7_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
      wd_exp |=> rst_o);
   // R6: a filtered external request starts a reset pulse
   a_r6_ext_resets: assert property (@(posedge clk) disable iff (!rst_n)
      ext_f |=> rst_o);
endmodule

// File: tb/sup_rst_seq_bench.sv
`timescale 1ns/1ps
module sup_rst_seq_bench;
   localparam int unsigned GC = 4;
   localparam int unsigned PT = 10;
   localparam int unsigned WT = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0, vlow_i = 1'b0, cs_i = 1'b0, ext_req_i = 1'b0;
   logic rst_o, rst_n_o;
   int   n_chk = 0, n_err = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   sup_rst_seq #(.GLITCH_CYC(GC), .PULSE_TICKS(PT), .WDOG_TICKS(WT)) u_sup_rst_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vlow_i(vlow_i), .cs_i(cs_i),
      .ext_req_i(ext_req_i), .rst_o(rst_o), .rst_n_o(rst_n_o));

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1; cyc(1); tick_i = 1'b0; cyc(1);
      end
   endtask

   task automatic toggle_cs();
      cs_i = ~cs_i; cyc(4);
   endtask

   task automatic chk(input string req, input logic exp_rst);
      n_chk++;
      if (rst_o !== exp_rst) begin
         n_err++;
         $display("FAIL %s: rst_o=%b expected %b", req, rst_o, exp_rst);
      end
      n_chk++;
      if (rst_n_o !== ~exp_rst) begin
         n_err++;
         $display("FAIL R1 (%s): rst_n_o=%b expected %b", req, rst_n_o, ~exp_rst);
      end
   endtask

   task automatic t_powerup();
      rst_n = 1'b0; cyc(5);
      chk("R2 in reset", 1'b1);
      rst_n = 1'b1; cyc(2);
      chk("R2 after reset", 1'b1);
      ticks(PT - 1); chk("R4 one tick short", 1'b1);
      ticks(1);      chk("R4 release", 1'b0);
   endtask

   task automatic t_vlow();
      toggle_cs();
      vlow_i = 1'b1; cyc(GC - 1); vlow_i = 1'b0; cyc(3);
      chk("R5 short glitch ignored", 1'b0);
      vlow_i = 1'b1; cyc(GC + 1);
      chk("R5 full-width low supply", 1'b1);
      ticks(PT + 10); chk("R3 held while low", 1'b1);
      vlow_i = 1'b0; cyc(2);
      ticks(PT - 1); chk("R4 after supply recovery short", 1'b1);
      ticks(1);      chk("R4 after supply recovery", 1'b0);
   endtask

   task automatic t_ext();
      toggle_cs();
      ext_req_i = 1'b1; cyc(GC - 1); ext_req_i = 1'b0; cyc(3);
      chk("R6 short request ignored", 1'b0);
      ext_req_i = 1'b1; cyc(GC); ext_req_i = 1'b0; cyc(2);
      chk("R6 request asserts", 1'b1);
      ticks(PT - 1); chk("R6 full pulse short", 1'b1);
      ticks(1);      chk("R6 full pulse end", 1'b0);
   endtask

   task automatic t_wdog();
      toggle_cs();
      ticks(WT - 1); chk("R7 before expiry", 1'b0);
      ticks(1); cyc(1); chk("R7 expiry", 1'b1);
      ticks(PT - 1); chk("R7 pulse short", 1'b1);
      ticks(1);      chk("R7 pulse end", 1'b0);
   endtask

   task automatic t_cs();
      toggle_cs();
      ticks(WT - 2);
      toggle_cs();
      ticks(WT - 1); chk("R8 restart by edge A", 1'b0);
      toggle_cs();
      ticks(WT - 1); chk("R8 restart by edge B", 1'b0);
      ticks(1); cyc(1); chk("R8 expiry after restart", 1'b1);
      ticks(PT);     chk("R8 pulse end", 1'b0);
   endtask

   task automatic t_idle();
      toggle_cs();
      vlow_i = 1'b1; cyc(GC + 2);
      ticks(WT + 5); chk("R9 reset while low", 1'b1);
      vlow_i = 1'b0; cyc(2);
      ticks(PT);     chk("R9 release", 1'b0);
      ticks(WT - 1); chk("R9 count not carried", 1'b0);
      ticks(1); cyc(1); chk("R9 fresh expiry", 1'b1);
      ticks(PT);     chk("R9 pulse end", 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_powerup();
      t_vlow();
      t_ext();
      t_wdog();
      t_cs();
      t_idle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule